// File: doc/BRIEF.md
# Audio Power-Down and Clock-Loss Sequencer

This block controls the shutdown and wake-up of a digital audio output path. When software clears the power bit in its control byte, the block mutes the output first. It then switches off the external power stage and finally gates the clock to the internal audio logic. The control-bus logic is never gated. When the power bit is set again, the same steps run in reverse: the clock comes back, then the power stage, then the mute is lifted.

The block runs on a free-running reference clock and watches the asynchronous master clock through a synchronizer. If the master clock stops for long enough, the block declares it lost. It can then shut off the power stage by itself. In binary output mode it also asks the modulator for a fixed 50% duty output.

The block has two further input protections. Input data flagged as invalid can mute the output. A frame-clock edge that arrives too soon after an accepted one can be dropped.

The sequencer has six states:
- `ST_RUN`: normal operation.
- `ST_MUTING`: mute requested, waiting for the mute to complete.
- `ST_PSTAGE_OFF`: power stage off.
- `ST_CLK_GATED`: audio clock stopped.
- `ST_WAKE_PSTAGE`: clock restored, power stage still off.
- `ST_WAKE_MUTE`: power stage on, mute still held.

The transitions are:
- `ST_RUN` to `ST_MUTING` when the power bit reads 0.
- `ST_MUTING` to `ST_PSTAGE_OFF` when `mute_done` is 1.
- `ST_PSTAGE_OFF` to `ST_CLK_GATED` unconditionally.
- `ST_CLK_GATED` to `ST_WAKE_PSTAGE` when the power bit reads 1.
- `ST_WAKE_PSTAGE` to `ST_WAKE_MUTE` unconditionally.
- `ST_WAKE_MUTE` to `ST_RUN` unconditionally.

Top module: `audio_pwr_seq`

## Requirements
- R1: After reset, `mute_req`, `pstage_off`, `mclk_lost`, `force_half` and `frame_pulse` are 0 and `clk_en` is 1, provided the master clock is toggling.
- R2: In `ST_RUN` with `ctrl[7]` = 0, `mute_req` goes to 1 at the next clock edge. `pstage_off` stays 0 for as long as `mute_done` stays 0.
- R3: When `mute_done` is 1 in `ST_MUTING`, `pstage_off` goes to 1 at the next edge and `clk_en` goes to 0 one edge later. While `clk_en` is 0, both `pstage_off` and `mute_req` stay 1. `clk_en` is driven straight from a register.
- R4: When `ctrl[7]` = 1 in `ST_CLK_GATED`, `clk_en` goes to 1 at the next edge. `pstage_off` goes to 0 one edge after that, and `mute_req` goes to 0 one edge after that.
- R5: A change of `ctrl[7]` during a power-down or wake-up sequence has no effect until that sequence has reached `ST_CLK_GATED` or `ST_RUN`. It is acted on from that state.
- R6: `mclk_lost` goes to 1 once `LOSS_CYC` reference cycles pass with no `mclk_in` edge seen after a two-flop synchronizer. It returns to 0 after the next edge.
- R7: With `ctrl[5]` = 1, a lost master clock drives `pstage_off` to 1 one cycle after `mclk_lost`, without muting. With `ctrl[5]` = 0, a lost clock leaves `pstage_off` unchanged.
- R8: `force_half` is 1 one cycle after `mclk_lost` is 1, but only when `ctrl[3]` = 1 and `bin_mode` = 1. Otherwise it is 0.
- R9: With `ctrl[2]` = 1, `data_invalid` = 1 sets `mute_req` to 1 at the next edge. With `ctrl[2]` = 0, `data_invalid` is ignored.
- R10: `frame_pulse` marks each accepted rising edge of `frame_in`. With `ctrl[4]` = 1, a rising edge that comes fewer than `FRAME_GUARD`+1 cycles after the previous accepted edge is dropped. With `ctrl[4]` = 0, every rising edge is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl | input | 8 | Control byte. Bit 7: power (1 = run). Bit 5: auto power-stage off on clock loss. Bit 4: frame guard. Bit 3: binary loss handling. Bit 2: invalid-input mute |
| mclk_in | input | 1 | Asynchronous master clock being monitored |
| bin_mode | input | 1 | Output path is in binary mode |
| data_invalid | input | 1 | Incoming audio data judged invalid |
| frame_in | input | 1 | Raw frame clock |
| mute_done | input | 1 | Soft mute has reached silence |
| mute_req | output | 1 | Soft-mute request |
| pstage_off | output | 1 | External power-stage power-down |
| clk_en | output | 1 | Registered clock-gate enable for the audio logic |
| mclk_lost | output | 1 | Master clock declared lost |
| force_half | output | 1 | Force a 50% duty output |
| frame_pulse | output | 1 | One-cycle pulse per accepted frame edge |

## Verification
The assertions assume that `ctrl`, `bin_mode`, `data_invalid` and `mute_done` are synchronous to `clk`. They also assume that the only asynchronous input is `mclk_in`, and that it enters only through the synchronizer. The bench changes every synchronous input at the falling edge of `clk` and runs the master clock from an unrelated period. It raises `mute_done` only while a mute is pending and holds `ctrl` steady during each frame-guard window. Under these conditions, the bench can observe the gating order, the release order and the frame spacing exactly as the properties describe them.

// File: rtl/apsq_pkg.sv
package apsq_pkg;
    typedef enum logic [2:0] {
        ST_RUN,
        ST_MUTING,
        ST_PSTAGE_OFF,
        ST_CLK_GATED,
        ST_WAKE_PSTAGE,
        ST_WAKE_MUTE
    } seq_state_t;

    localparam int PWR_BIT     = 7;
    localparam int AUTO_BIT    = 5;
    localparam int GUARD_BIT   = 4;
    localparam int BINLOSS_BIT = 3;
    localparam int INVMUTE_BIT = 2;
endpackage

// File: rtl/apsq_mclk_monitor.sv
module apsq_mclk_monitor #(
    parameter int LOSS_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mclk_in,
    output logic lost
);
    localparam int CW = $clog2(LOSS_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(LOSS_CYC);

    logic [2:0]    sync_q;
    logic [CW-1:0] gap_q;
    logic          edge_seen;

    // two synchronizer stages plus one history stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], mclk_in};
    end

    assign edge_seen = sync_q[2] ^ sync_q[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           gap_q <= '0;
        else if (edge_seen)   gap_q <= '0;
        else if (gap_q != LIMIT) gap_q <= gap_q + 1'b1;
    end

    assign lost = (gap_q == LIMIT);
endmodule

// File: rtl/apsq_frame_guard.sv
module apsq_frame_guard #(
    parameter int FRAME_GUARD = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_in,
    input  logic guard_en,
    output logic pulse
);
    localparam int GW = $clog2(FRAME_GUARD + 1);
    localparam logic [GW-1:0] GMAX = GW'(FRAME_GUARD);

    logic [2:0]    fsync_q;
    logic [GW-1:0] since_q;
    logic          rise, accept;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsync_q <= '0;
        else        fsync_q <= {fsync_q[1:0], frame_in};
    end

    assign rise   = fsync_q[1] & ~fsync_q[2];
    assign accept = rise & (~guard_en | (since_q == GMAX));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= GMAX;
            pulse   <= 1'b0;
        end else begin
            pulse <= accept;
            if (accept)              since_q <= '0;
            else if (since_q != GMAX) since_q <= since_q + 1'b1;
        end
    end
endmodule

// File: rtl/apsq_seq_fsm.sv
module apsq_seq_fsm
    import apsq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_on,
    input  logic mute_done,
    output logic seq_mute,
    output logic seq_pstage,
    output logic seq_clk_en
);
    seq_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:         if (!pwr_on)   state_d = ST_MUTING;
            ST_MUTING:      if (mute_done) state_d = ST_PSTAGE_OFF;
            ST_PSTAGE_OFF:                 state_d = ST_CLK_GATED;
            ST_CLK_GATED:   if (pwr_on)    state_d = ST_WAKE_PSTAGE;
            ST_WAKE_PSTAGE:                state_d = ST_WAKE_MUTE;
            ST_WAKE_MUTE:                  state_d = ST_RUN;
            default:                       state_d = ST_RUN;
        endcase
    end

    // outputs registered from the next state: clock gate is glitch-free
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_mute   <= 1'b0;
            seq_pstage <= 1'b0;
            seq_clk_en <= 1'b1;
        end else begin
            unique case (state_d)
                ST_RUN:         begin seq_mute <= 1'b0; seq_pstage <= 1'b0; seq_clk_en <= 1'b1; end
                ST_MUTING:      begin seq_mute <= 1'b1; seq_pstage <= 1'b0; seq_clk_en <= 1'b1; end
                ST_PSTAGE_OFF:  begin seq_mute <= 1'b1; seq_pstage <= 1'b1; seq_clk_en <= 1'b1; end
                ST_CLK_GATED:   begin seq_mute <= 1'b1; seq_pstage <= 1'b1; seq_clk_en <= 1'b0; end
                ST_WAKE_PSTAGE: begin seq_mute <= 1'b1; seq_pstage <= 1'b1; seq_clk_en <= 1'b1; end
                ST_WAKE_MUTE:   begin seq_mute <= 1'b1; seq_pstage <= 1'b0; seq_clk_en <= 1'b1; end
                default:        begin seq_mute <= 1'b0; seq_pstage <= 1'b0; seq_clk_en <= 1'b1; end
            endcase
        end
    end
endmodule

// File: rtl/audio_pwr_seq.sv
module audio_pwr_seq
    import apsq_pkg::*;
#(
    parameter int LOSS_CYC    = 16,
    parameter int FRAME_GUARD = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] ctrl,
    input  logic       mclk_in,
    input  logic       bin_mode,
    input  logic       data_invalid,
    input  logic       frame_in,
    input  logic       mute_done,
    output logic       mute_req,
    output logic       pstage_off,
    output logic       clk_en,
    output logic       mclk_lost,
    output logic       force_half,
    output logic       frame_pulse
);
    logic seq_mute, seq_pstage;
    logic inv_mute_q, auto_off_q;

    apsq_mclk_monitor #(.LOSS_CYC(LOSS_CYC)) u_mon (
        .clk(clk), .rst_n(rst_n), .mclk_in(mclk_in), .lost(mclk_lost)
    );

    apsq_frame_guard #(.FRAME_GUARD(FRAME_GUARD)) u_fg (
        .clk(clk), .rst_n(rst_n), .frame_in(frame_in),
        .guard_en(ctrl[GUARD_BIT]), .pulse(frame_pulse)
    );

    apsq_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .pwr_on(ctrl[PWR_BIT]), .mute_done(mute_done),
        .seq_mute(seq_mute), .seq_pstage(seq_pstage), .seq_clk_en(clk_en)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inv_mute_q <= 1'b0;
            auto_off_q <= 1'b0;
            force_half <= 1'b0;
        end else begin
            inv_mute_q <= ctrl[INVMUTE_BIT] & data_invalid;
            auto_off_q <= ctrl[AUTO_BIT] & mclk_lost;
            force_half <= ctrl[BINLOSS_BIT] & bin_mode & mclk_lost;
        end
    end

    assign mute_req   = seq_mute | inv_mute_q;
    assign pstage_off = seq_pstage | auto_off_q;
endmodule

// File: rtl/audio_pwr_seq_chk.sv
module audio_pwr_seq_chk #(
    parameter int FRAME_GUARD = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] ctrl,
    input logic       data_invalid,
    input logic       mute_req,
    input logic       pstage_off,
    input logic       clk_en,
    input logic       mclk_lost,
    input logic       force_half,
    input logic       frame_pulse
);
    localparam int GW = $clog2(FRAME_GUARD + 1);
    localparam logic [GW-1:0] GMAX = GW'(FRAME_GUARD);

    logic [GW-1:0] gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             gap_q <= GMAX;
        else if (frame_pulse)   gap_q <= '0;
        else if (gap_q != GMAX) gap_q <= gap_q + 1'b1;
    end

    // R2: power stage only switched by the sequence after the mute request
    assert_mute_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pstage_off) && !$past(ctrl[5] && mclk_lost) |-> $past(mute_req));

    assert_gate_after_pstage_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_en) |-> $past(pstage_off));

    assert_gated_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |-> pstage_off && mute_req);

    assert_ungate_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_en) |-> pstage_off && mute_req);

    assert_force_needs_loss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        force_half |-> $past(mclk_lost));

    assert_invalid_mutes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[2] && data_invalid |=> mute_req);

    assert_frame_spacing_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse && $past(ctrl[4]) |-> gap_q == GMAX);
endmodule

bind audio_pwr_seq audio_pwr_seq_chk #(.FRAME_GUARD(FRAME_GUARD)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .data_invalid(data_invalid),
    .mute_req(mute_req), .pstage_off(pstage_off), .clk_en(clk_en),
    .mclk_lost(mclk_lost), .force_half(force_half), .frame_pulse(frame_pulse)
);

// File: tb/sim_audio_pwr_seq.sv
`timescale 1ns/1ps
module sim_audio_pwr_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ctrl = 8'b1001_1100;
    logic       mclk = 1'b0;
    logic       mclk_run = 1'b1;
    logic       bin_mode = 1'b0;
    logic       data_invalid = 1'b0;
    logic       frame_in = 1'b0;
    logic       mute_done = 1'b0;
    logic       mute_req, pstage_off, clk_en, mclk_lost, force_half, frame_pulse;

    int checks = 0;
    int fails = 0;
    int pulses = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;
    always begin
        #7;
        if (mclk_run) mclk = ~mclk;
    end

    audio_pwr_seq u0 (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .mclk_in(mclk), .bin_mode(bin_mode),
        .data_invalid(data_invalid), .frame_in(frame_in), .mute_done(mute_done),
        .mute_req(mute_req), .pstage_off(pstage_off), .clk_en(clk_en),
        .mclk_lost(mclk_lost), .force_half(force_half), .frame_pulse(frame_pulse)
    );

    always @(negedge clk) if (rst_n && frame_pulse) pulses++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 mute_req", mute_req, 0);
        chk("R1 pstage_off", pstage_off, 0);
        chk("R1 clk_en", clk_en, 1);
        chk("R1 mclk_lost", mclk_lost, 0);
        chk("R1 force_half", force_half, 0);
        chk("R1 frame_pulse", frame_pulse, 0);
    endtask

    task automatic t_power_cycle;
        ctrl[7] = 1'b0; step(1);
        chk("R2 mute_req raised", mute_req, 1);
        step(5);
        chk("R2 pstage waits for mute", pstage_off, 0);
        chk("R2 clk still on", clk_en, 1);
        mute_done = 1'b1; step(1);
        chk("R3 pstage_off on", pstage_off, 1);
        chk("R3 clk_en before gate", clk_en, 1);
        mute_done = 1'b0; step(1);
        chk("R3 clk gated", clk_en, 0);
        step(3);
        chk("R3 gated holds pstage", pstage_off, 1);
        chk("R3 gated holds mute", mute_req, 1);
        ctrl[7] = 1'b1; step(1);
        chk("R4 clk ungated", clk_en, 1);
        chk("R4 pstage still off", pstage_off, 1);
        step(1);
        chk("R4 pstage released", pstage_off, 0);
        chk("R4 mute still held", mute_req, 1);
        step(1);
        chk("R4 mute released", mute_req, 0);
    endtask

    task automatic t_ignored_request;
        ctrl[7] = 1'b0; step(1);
        ctrl[7] = 1'b1; step(3);
        chk("R5 still muting", mute_req, 1);
        chk("R5 pstage not yet", pstage_off, 0);
        mute_done = 1'b1; step(1);
        mute_done = 1'b0;
        chk("R5 sequence continues", pstage_off, 1);
        step(1);
        chk("R5 reaches gate", clk_en, 0);
        step(1);
        chk("R5 wake acted on", clk_en, 1);
        step(2);
        chk("R5 back in run mute", mute_req, 0);
        chk("R5 back in run pstage", pstage_off, 0);
    endtask

    task automatic t_clock_loss;
        ctrl[5] = 1'b1; mclk_run = 1'b0; step(8);
        chk("R6 not lost early", mclk_lost, 0);
        step(22);
        chk("R6 lost declared", mclk_lost, 1);
        chk("R7 auto pstage off", pstage_off, 1);
        chk("R7 no mute on auto off", mute_req, 0);
        mclk_run = 1'b1; step(6);
        chk("R6 loss cleared", mclk_lost, 0);
        chk("R7 pstage back on", pstage_off, 0);
        ctrl[5] = 1'b0; mclk_run = 1'b0; step(30);
        chk("R6 lost again", mclk_lost, 1);
        chk("R7 auto disabled", pstage_off, 0);
        bin_mode = 1'b1; step(2);
        chk("R8 force in binary", force_half, 1);
        bin_mode = 1'b0; step(2);
        chk("R8 no force outside binary", force_half, 0);
        bin_mode = 1'b1; ctrl[3] = 1'b0; step(2);
        chk("R8 no force when disabled", force_half, 0);
        ctrl[3] = 1'b1; bin_mode = 1'b0;
        mclk_run = 1'b1; step(6);
        chk("R6 recovered", mclk_lost, 0);
    endtask

    task automatic t_invalid;
        data_invalid = 1'b1; step(1);
        chk("R9 invalid mutes", mute_req, 1);
        ctrl[2] = 1'b0; step(2);
        chk("R9 ignored when disabled", mute_req, 0);
        data_invalid = 1'b0; ctrl[2] = 1'b1; step(2);
        chk("R9 clear", mute_req, 0);
    endtask

    task automatic frame_pair(input int gap);
        frame_in = 1'b1; step(1);
        frame_in = 1'b0; step(gap - 1);
        frame_in = 1'b1; step(1);
        frame_in = 1'b0; step(20);
    endtask

    task automatic t_frame;
        int p0;
        p0 = pulses; frame_pair(2);
        chk("R10 close edge dropped", pulses - p0, 1);
        ctrl[4] = 1'b0;
        p0 = pulses; frame_pair(2);
        chk("R10 no guard accepts both", pulses - p0, 2);
        ctrl[4] = 1'b1;
        p0 = pulses; frame_pair(12);
        chk("R10 spaced edges accepted", pulses - p0, 2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(4);
        t_reset();
        t_power_cycle();
        step(3);
        t_ignored_request();
        step(3);
        t_clock_loss();
        t_invalid();
        t_frame();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule